// File: doc/BRIEF.md
# Host Mailbox Port for an Internal Byte Register Space

This block is the device end of a two-port byte mailbox. Through it a host reaches a 256-entry internal byte register space. The host sees two byte-wide locations. Offset 0 is the data port. Offset 4 returns a status byte when read and takes a command byte when written. Two status flags pace the host. One flag shows that the block has not yet taken in the last byte the host wrote. The other shows that a result byte is waiting to be read.

A read is one command byte followed by one address byte. A write is one command byte, then an address byte, then a data byte. Each byte the host writes is latched at once. It is then consumed after a programmable number of cycles. When the block consumes the last byte of a sequence, it raises a single-cycle strobe toward the register space, with the address, the direction and the write data. The register space returns read data one cycle after the strobe. That data goes into the output buffer for the host to collect.

Top module: `ecmb_port`

## Requirements
- R1: After reset the status byte reads 0x00, so both flags are clear, and offset 0 reads 0x00.
- R2: The status byte at offset 4 carries the input-busy flag in bit 1 and the result-ready flag in bit 0, and its bits 7..2 read 0. A host write to any offset other than 0 or 4 is ignored and leaves the input-busy flag clear. A host read of any such offset returns 0x00.
- R3: A host write to offset 0 or 4 sets the input-busy flag from the next cycle. The flag then stays set for exactly CONSUME_CYCLES cycles.
- R4: Command 0x80 followed by an address byte on offset 0 produces one read strobe for that address. The addressed byte then appears at offset 0. The result-ready flag sets exactly CONSUME_CYCLES+1 cycles after the clock edge that took the address byte.
- R5: Command 0x81 followed by an address byte and then a data byte on offset 0 produces one write strobe carrying that address and data, and the register space stores the byte.
- R6: A host read of offset 0 clears the result-ready flag from the next cycle.
- R7: A command byte other than 0x80 or 0x81 is ignored and returns the sequencer to idle. Data bytes that follow it produce no strobe.
- R8: A new command received in the middle of a sequence abandons that sequence. Decoding restarts from the new command, and the abandoned sequence issues no strobe.
- R9: A data byte written while no command is pending produces no strobe.
- R10: Each register-space strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HA_W | Host byte offset: 0 is data, 4 is status/command |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte returned to the host, selected by host_addr |
| rs_req | output | 1 | Register-space access strobe |
| rs_we | output | 1 | Strobe direction, 1 for a write |
| rs_addr | output | AW | Register-space byte address |
| rs_wdata | output | 8 | Register-space write data |
| rs_rdata | input | 8 | Register-space read data, valid one cycle after a read strobe |

## Verification
The assertions assume that the host follows the pacing rules. That means the host never writes while the input-busy flag is set, and it never asserts write and read in the same cycle. They also assume that the register space presents read data on the cycle after a read strobe. The bench stays within these rules. It polls the status byte until the busy flag clears before every command or data write, and it polls for the ready flag before it reads the data port. Its register-space model registers read data on every clock edge. It never breaks these rules, even in the abort and illegal-command cases.

// File: rtl/ecmb_pkg.sv
package ecmb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h81;
  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_RD_WAIT, S_WR_ADDR, S_WR_DATA
  } seq_state_t;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_t;

  function automatic op_t decode_cmd(input logic [BYTE_W-1:0] b);
    if (b == CMD_READ)       return OP_READ;
    else if (b == CMD_WRITE) return OP_WRITE;
    else                     return OP_NONE;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic busy,
                                                    input logic ready);
    return {{(BYTE_W-2){1'b0}}, busy, ready};
  endfunction
endpackage

// File: rtl/ecmb_ibf_timer.sv
module ecmb_ibf_timer #(
  parameter int CONSUME_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic consume
);
  localparam int CW = $clog2(CONSUME_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONSUME_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(1);

  logic [CW-1:0] cnt;

  assign consume = busy && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (consume) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt - CNT_LAST;
    end
  end

  p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !load) |=> !busy);
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CNT_LAST && cnt <= CNT_LOAD));
endmodule

// File: rtl/ecmb_seq.sv
module ecmb_seq
  import ecmb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_is_cmd,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              consume,
  output logic              rs_req,
  output logic              rs_we,
  output logic [AW-1:0]     rs_addr,
  output logic [BYTE_W-1:0] rs_wdata,
  output logic              capture
);
  seq_state_t        state;
  logic [BYTE_W-1:0] pend_byte;
  logic              pend_cmd;
  logic [AW-1:0]     wr_addr;
  logic              cmd_done;
  logic              data_done;

  assign cmd_done  = consume && pend_cmd;
  assign data_done = consume && !pend_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_byte <= '0;
      pend_cmd  <= 1'b0;
    end else if (load) begin
      pend_byte <= load_byte;
      pend_cmd  <= load_is_cmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wr_addr <= '0;
    end else if (cmd_done) begin
      case (decode_cmd(pend_byte))
        OP_READ:  state <= S_RD_ADDR;
        OP_WRITE: state <= S_WR_ADDR;
        default:  state <= S_IDLE;
      endcase
    end else if (state == S_RD_WAIT) begin
      state <= S_IDLE;
    end else if (data_done) begin
      case (state)
        S_RD_ADDR: state <= S_RD_WAIT;
        S_WR_ADDR: begin
          wr_addr <= pend_byte[AW-1:0];
          state   <= S_WR_DATA;
        end
        S_WR_DATA: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign rs_req   = data_done && (state == S_RD_ADDR || state == S_WR_DATA);
  assign rs_we    = (state == S_WR_DATA);
  assign rs_addr  = (state == S_RD_ADDR) ? pend_byte[AW-1:0] : wr_addr;
  assign rs_wdata = pend_byte;
  assign capture  = (state == S_RD_WAIT);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rs_req |=> !rs_req);
  p_capture_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> $past(rs_req && !rs_we));
  p_cmd_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (state == S_IDLE || state == S_RD_ADDR || state == S_WR_ADDR));
  p_idle_data_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && state == S_IDLE) |-> !rs_req);
endmodule

// File: rtl/ecmb_obuf.sv
module ecmb_obuf
  import ecmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BYTE_W-1:0] din,
  input  logic              clear,
  output logic              ready,
  output logic [BYTE_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      dout  <= '0;
    end else if (capture) begin
      ready <= 1'b1;
      dout  <= din;
    end else if (clear) begin
      ready <= 1'b0;
    end
  end

  p_ready_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !capture) |=> !ready);
  p_ready_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (ready && dout == $past(din)));
endmodule

// File: rtl/ecmb_port.sv
module ecmb_port
  import ecmb_pkg::*;
#(
  parameter int CONSUME_CYCLES = 2,
  parameter int AW             = 8,
  parameter int HA_W           = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HA_W-1:0]   host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              rs_req,
  output logic              rs_we,
  output logic [AW-1:0]     rs_addr,
  output logic [BYTE_W-1:0] rs_wdata,
  input  logic [BYTE_W-1:0] rs_rdata
);
  logic              sel_data, sel_ctrl;
  logic              wr_accept;
  logic              busy, consume, capture, ready;
  logic [BYTE_W-1:0] obuf;

  assign sel_data  = (host_addr == HA_W'(OFS_DATA));
  assign sel_ctrl  = (host_addr == HA_W'(OFS_CTRL));
  assign wr_accept = host_wr && (sel_data || sel_ctrl);

  ecmb_ibf_timer #(.CONSUME_CYCLES(CONSUME_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(wr_accept),
    .busy(busy), .consume(consume)
  );

  ecmb_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(wr_accept), .load_is_cmd(sel_ctrl),
    .load_byte(host_wdata), .consume(consume),
    .rs_req(rs_req), .rs_we(rs_we), .rs_addr(rs_addr),
    .rs_wdata(rs_wdata), .capture(capture)
  );

  ecmb_obuf u_obuf (
    .clk(clk), .rst_n(rst_n), .capture(capture), .din(rs_rdata),
    .clear(host_rd && sel_data), .ready(ready), .dout(obuf)
  );

  always_comb begin
    if (sel_ctrl)      host_rdata = pack_status(busy, ready);
    else if (sel_data) host_rdata = obuf;
    else               host_rdata = '0;
  end

  p_other_ofs_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !sel_data && !sel_ctrl && !busy) |=> !busy);
  p_status_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |-> (host_rdata[BYTE_W-1:2] == '0));
endmodule

// File: tb/sim_ecmb_port.sv
module sim_ecmb_port;
  localparam int N   = 2;
  localparam int AW  = 8;
  localparam int DEP = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = 3'd4;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       rs_req, rs_we;
  logic [AW-1:0] rs_addr;
  logic [7:0] rs_wdata;
  logic [7:0] rs_rdata = 8'h00;

  logic [7:0] mem [DEP];
  logic [7:0] exp_mem [DEP];
  int n_tests = 0, n_fail = 0, strobes = 0, wide_err = 0, cyc = 0;
  logic prev_req = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  ecmb_port #(.CONSUME_CYCLES(N), .AW(AW), .HA_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rs_req(rs_req), .rs_we(rs_we), .rs_addr(rs_addr),
    .rs_wdata(rs_wdata), .rs_rdata(rs_rdata)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  // register-space model
  always @(posedge clk) begin
    if (rs_req && rs_we) mem[rs_addr] <= rs_wdata;
    rs_rdata <= mem[rs_addr];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rs_req) strobes++;
      if (rs_req && prev_req) wide_err++;
      prev_req = rs_req;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 3'd4;
    #1;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; host_addr = 3'd4;
    #1;
  endtask

  task automatic wait_busy();
    int polls = 0;
    while (host_rdata[1] && polls < 500) begin
      @(negedge clk); #1; polls++;
    end
    if (polls >= 500) chk("R3 busy timeout", 1, 0);
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (!host_rdata[0] && k < 500) begin
      @(negedge clk); #1; k++;
    end
    if (k >= 500) chk("R4 ready timeout", 1, 0);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d, output int lat);
    wait_busy(); hwrite(3'd4, 8'h80);
    wait_busy(); hwrite(3'd0, a);
    wait_ready(lat);
    hread(3'd0, d);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    wait_busy(); hwrite(3'd4, 8'h81);
    wait_busy(); hwrite(3'd0, a);
    wait_busy(); hwrite(3'd0, d);
    wait_busy();
    exp_mem[a] = d;
  endtask

  initial begin
    logic [7:0] d;
    int lat, s0, k;
    for (int i = 0; i < DEP; i++) begin
      mem[i] = seed(i);
      exp_mem[i] = seed(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status after reset", host_rdata, 8'h00);
    host_addr = 3'd0; #1;
    chk("R1 data port after reset", host_rdata, 8'h00);
    host_addr = 3'd4; #1;

    // R2 other offsets
    hwrite(3'd2, 8'h80);
    chk("R2 write to offset 2 ignored", host_rdata[1], 1'b0);
    hread(3'd6, d);
    chk("R2 read of offset 6", d, 8'h00);

    // R3 busy duration (unknown command, harmless)
    hwrite(3'd4, 8'h3C);
    k = 0;
    while (host_rdata[1] && k < 50) begin k++; @(negedge clk); #1; end
    chk("R3 busy cycles", k, N);
    chk("R2 status upper bits", host_rdata[7:2], 6'd0);

    // R4 exhaustive read sweep with latency check
    for (int a = 0; a < DEP; a++) begin
      s0 = strobes;
      do_read(8'(a), d, lat);
      chk("R4 read data", d, exp_mem[a]);
      chk("R4 one strobe per read", strobes - s0, 1);
      if (a == 0 || a == DEP - 1) chk("R4 ready latency", lat, N + 1);
      if (a == 5) chk("R6 ready cleared by read", host_rdata[0], 1'b0);
    end

    // R5 exhaustive write sweep, then read back
    for (int a = 0; a < DEP; a++) begin
      s0 = strobes;
      do_write(8'(a), 8'((a ^ 8'hA5) + 3));
      chk("R5 one strobe per write", strobes - s0, 1);
    end
    for (int a = 0; a < DEP; a++) begin
      do_read(8'(a), d, lat);
      chk("R5 write readback", d, exp_mem[a]);
    end

    // R7 illegal command sweep
    s0 = strobes;
    for (int c = 0; c < 256; c++) begin
      if (c != 8'h80 && c != 8'h81) begin
        wait_busy(); hwrite(3'd4, 8'(c));
        wait_busy(); hwrite(3'd0, 8'h33);
        wait_busy(); hwrite(3'd0, 8'h44);
        wait_busy();
      end
    end
    chk("R7 no strobe after illegal commands", strobes - s0, 0);
    chk("R7 ready stays clear", host_rdata[0], 1'b0);
    // illegal command inside a write sequence
    wait_busy(); hwrite(3'd4, 8'h81);
    wait_busy(); hwrite(3'd4, 8'h55);
    wait_busy(); hwrite(3'd0, 8'h33);
    wait_busy(); hwrite(3'd0, 8'h99);
    wait_busy();
    chk("R7 illegal command aborts write", strobes - s0, 0);
    do_read(8'h33, d, lat);
    chk("R7 target unchanged", d, exp_mem[8'h33]);

    // R8 write sequence abandoned by read command
    s0 = strobes;
    wait_busy(); hwrite(3'd4, 8'h81);
    wait_busy(); hwrite(3'd0, 8'h10);
    wait_busy(); hwrite(3'd4, 8'h80);
    wait_busy(); hwrite(3'd0, 8'h20);
    wait_ready(lat); hread(3'd0, d);
    chk("R8 restarted read data", d, exp_mem[8'h20]);
    chk("R8 single strobe", strobes - s0, 1);
    do_read(8'h10, d, lat);
    chk("R8 abandoned write left target", d, exp_mem[8'h10]);
    // read sequence abandoned by write command
    s0 = strobes;
    wait_busy(); hwrite(3'd4, 8'h80);
    wait_busy(); hwrite(3'd4, 8'h81);
    wait_busy(); hwrite(3'd0, 8'h40);
    wait_busy(); hwrite(3'd0, 8'h7E);
    wait_busy();
    exp_mem[8'h40] = 8'h7E;
    chk("R8 no read result after abort", host_rdata[0], 1'b0);
    chk("R8 one write strobe", strobes - s0, 1);
    do_read(8'h40, d, lat);
    chk("R8 restarted write stored", d, 8'h7E);

    // R9 data byte with nothing pending
    s0 = strobes;
    wait_busy(); hwrite(3'd0, 8'h12);
    wait_busy(); hwrite(3'd0, 8'h34);
    wait_busy();
    chk("R9 no strobe for idle data", strobes - s0, 0);

    // R6 explicit
    wait_busy(); hwrite(3'd4, 8'h80);
    wait_busy(); hwrite(3'd0, 8'h01);
    wait_ready(lat);
    chk("R6 ready before read", host_rdata[0], 1'b1);
    hread(3'd0, d);
    chk("R6 ready after read", host_rdata[0], 1'b0);

    // R10 strobe width
    chk("R10 strobe width", wide_err, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule